// File: doc/BRIEF.md
# Set-Associative LRU Tag Tracker

This block keeps the tag-side state of a set-associative data cache and classifies every memory request as a hit, a miss, or a miss that displaces a valid line. The geometry is fixed at elaboration: `SET_BITS` picks 2^SET_BITS sets, `WAYS` gives the lines per set, and `BLK_BITS` gives a block of 2^BLK_BITS bytes. The block holds only valid bits, tags and recency ages. It has no data array, no write-back path and no memory port.

Each request carries a load/store flag and a 64-bit byte address. The block drops the low `BLK_BITS` offset bits, uses the next `SET_BITS` bits as the set number and keeps the remaining upper bits as the tag. One cycle after a request is accepted it raises exactly one of a hit or a miss pulse. An eviction pulse goes with a miss when the filled line was valid. Three running totals count hits, misses and evictions, and they can be read at any time. Replacement is true least-recently-used. The block's results match a trace replay of the same access stream exactly.

Top module: `lru_tag_cache`

## Requirements
- R1: A synchronous reset clears all three totals and all outcome pulses, and it invalidates every line, so the first access to any address after reset is a miss without eviction.
- R2: Address bits [BLK_BITS-1:0] are ignored. Bits [BLK_BITS+SET_BITS-1:BLK_BITS] select the set, and all higher bits form the tag. Two addresses in the same block give a hit on the second access.
- R3: Each accepted request (req_valid and req_ready high at a rising edge) produces exactly one of out_hit or out_miss in the following cycle. out_evict is only ever high together with out_miss. No pulse appears in a cycle that follows no accepted request.
- R4: Stores behave exactly like loads. A store miss allocates the line, so a later load to that block hits.
- R5: On a miss, an invalid way is filled before any valid way is replaced, choosing the lowest-numbered invalid way. Such a fill raises no eviction.
- R6: A miss in a full set replaces the least-recently-used way, and this raises out_evict. A hit or a fill makes the accessed way the most recently used.
- R7: hit_total, miss_total and evict_total each rise by one in the same cycle as their pulse and otherwise hold. evict_total never exceeds miss_total.
- R8: With SET_BITS=4, WAYS=2 and BLK_BITS=4, the sequence load 0x10, load 0x20, store 0x20, load 0x22, store 0x18, load 0x110, load 0x210, load 0x12, store 0x12 gives 4 hits, 5 misses and 2 evictions.
- R9: req_ready is high in every cycle, so requests may arrive back to back. A request sees the state left by the request of the cycle before, even when both fall in the same set.
- R10: After any stream of requests, hit_total plus miss_total equals the number of accepted requests, and the totals equal those of an LRU trace replay of the same stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_ready | output | 1 | Block can accept a request (always high) |
| req_store | input | 1 | 1 for a store, 0 for a load; no effect on the outcome |
| req_addr | input | ADDR_W (64) | Byte address of the access |
| out_hit | output | 1 | Pulse: the request of the previous cycle hit |
| out_miss | output | 1 | Pulse: the request of the previous cycle missed |
| out_evict | output | 1 | Pulse: that miss replaced a valid line |
| hit_total | output | CNT_W (32) | Running hit count |
| miss_total | output | CNT_W (32) | Running miss count |
| evict_total | output | CNT_W (32) | Running eviction count |

## Verification
The assertions assume that no request arrives while reset is high, that the counters never wrap within a run, and that every accepted request stays within one block, so the size of an access never matters. The stimulus keeps to these limits. It drives requests only after reset has been released for a cycle. Each run is a few hundred requests, far below the 32-bit wrap. It presents only byte addresses, with no size field. Reset is applied only when no outcome is still pending.

// File: rtl/lru_cache_pkg.sv
package lru_cache_pkg;
  // Positions of the three outcome events in the counter bump vector.
  localparam int EV_HIT   = 0;
  localparam int EV_MISS  = 1;
  localparam int EV_EVICT = 2;
  localparam int EV_COUNT = 3;

  // Width of an index that can name N items (never zero).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lru_way_match.sv
module lru_way_match #(
  parameter int WAYS   = 2,
  parameter int TAG_W  = 8,
  parameter int AGE_W  = 1,
  parameter int WIDX_W = 1
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [WAYS-1:0][AGE_W-1:0] row_age,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit,
  output logic [WIDX_W-1:0]          hit_way,
  output logic [WIDX_W-1:0]          fill_way,
  output logic                       fill_displaces
);
  logic [WAYS-1:0] tag_eq;
  logic [WAYS-1:0] is_oldest;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_eq[w]    = row_valid[w] && (row_tag[w] == look_tag);
    assign is_oldest[w] = (row_age[w] == AGE_W'(WAYS - 1));
  end

  assign hit            = |tag_eq;
  assign fill_displaces = &row_valid;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (tag_eq[w]) hit_way = WIDX_W'(w);
  end

  // Oldest way by default; the lowest free way overrides it.
  always_comb begin
    fill_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (is_oldest[w]) fill_way = WIDX_W'(w);
    if (!(&row_valid))
      for (int w = WAYS - 1; w >= 0; w--)
        if (!row_valid[w]) fill_way = WIDX_W'(w);
  end
endmodule

// File: rtl/lru_age_update.sv
module lru_age_update #(
  parameter int WAYS   = 2,
  parameter int AGE_W  = 1,
  parameter int WIDX_W = 1
) (
  input  logic [WAYS-1:0][AGE_W-1:0] age_in,
  input  logic [WIDX_W-1:0]          touch_way,
  output logic [WAYS-1:0][AGE_W-1:0] age_out
);
  logic [AGE_W-1:0] pivot;

  // Ages form a permutation of 0..WAYS-1; 0 is most recent.
  always_comb begin
    pivot = age_in[touch_way];
    for (int w = 0; w < WAYS; w++) begin
      if (WIDX_W'(w) == touch_way)  age_out[w] = '0;
      else if (age_in[w] < pivot)   age_out[w] = age_in[w] + AGE_W'(1);
      else                          age_out[w] = age_in[w];
    end
  end
endmodule

// File: rtl/lru_event_counters.sv
module lru_event_counters
  import lru_cache_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [EV_COUNT-1:0]           bump,
  output logic [EV_COUNT-1:0][CNT_W-1:0] totals
);
  for (genvar i = 0; i < EV_COUNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)          totals[i] <= '0;
      else if (bump[i]) totals[i] <= totals[i] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lru_tag_cache.sv
module lru_tag_cache
  import lru_cache_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SET_BITS = 4,
  parameter int WAYS     = 2,
  parameter int BLK_BITS = 4,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_hit,
  output logic              out_miss,
  output logic              out_evict,
  output logic [CNT_W-1:0]  hit_total,
  output logic [CNT_W-1:0]  miss_total,
  output logic [CNT_W-1:0]  evict_total
);
  localparam int NSETS  = 1 << SET_BITS;
  localparam int TAG_W  = ADDR_W - SET_BITS - BLK_BITS;
  localparam int WIDX_W = idx_width(WAYS);
  localparam int AGE_W  = WIDX_W;
  localparam int SIDX_W = idx_width(NSETS);

  function automatic logic [SIDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] sh;
    sh = a >> BLK_BITS;
    return SIDX_W'(sh) & SIDX_W'(NSETS - 1);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> (BLK_BITS + SET_BITS));
  endfunction

  logic [NSETS-1:0][WAYS-1:0]            valid_q;
  logic [NSETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [NSETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

  logic [SIDX_W-1:0]          look_set;
  logic [TAG_W-1:0]           look_tag;
  logic                       look_hit;
  logic [WIDX_W-1:0]          hit_way;
  logic [WIDX_W-1:0]          fill_way;
  logic [WIDX_W-1:0]          touch_way;
  logic                       fill_displaces;
  logic [WAYS-1:0][AGE_W-1:0] age_next;
  logic                       fire;
  logic                       ev_hit, ev_miss, ev_evict;
  logic                       unused_store;
  logic [EV_COUNT-1:0][CNT_W-1:0] totals;

  assign req_ready    = 1'b1;
  assign unused_store = req_store;   // stores are classified like loads
  assign fire         = req_valid && req_ready;
  assign look_set     = set_of(req_addr);
  assign look_tag     = tag_of(req_addr);

  lru_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .WIDX_W(WIDX_W)) u_match (
    .row_valid      (valid_q[look_set]),
    .row_tag        (tag_q[look_set]),
    .row_age        (age_q[look_set]),
    .look_tag       (look_tag),
    .hit            (look_hit),
    .hit_way        (hit_way),
    .fill_way       (fill_way),
    .fill_displaces (fill_displaces)
  );

  assign touch_way = look_hit ? hit_way : fill_way;

  lru_age_update #(.WAYS(WAYS), .AGE_W(AGE_W), .WIDX_W(WIDX_W)) u_age (
    .age_in    (age_q[look_set]),
    .touch_way (touch_way),
    .age_out   (age_next)
  );

  assign ev_hit   = fire && look_hit;
  assign ev_miss  = fire && !look_hit;
  assign ev_evict = ev_miss && fill_displaces;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
      out_evict <= 1'b0;
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else begin
      out_hit   <= ev_hit;
      out_miss  <= ev_miss;
      out_evict <= ev_evict;
      if (fire) begin
        age_q[look_set] <= age_next;
        if (!look_hit) begin
          valid_q[look_set][fill_way] <= 1'b1;
          tag_q[look_set][fill_way]   <= look_tag;
        end
      end
    end
  end

  lru_event_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .bump   ({ev_evict, ev_miss, ev_hit}),
    .totals (totals)
  );

  assign hit_total   = totals[EV_HIT];
  assign miss_total  = totals[EV_MISS];
  assign evict_total = totals[EV_EVICT];
endmodule

// File: rtl/lru_tag_cache_chk.sv
module lru_tag_cache_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             out_hit,
  input logic             out_miss,
  input logic             out_evict,
  input logic [CNT_W-1:0] hit_total,
  input logic [CNT_W-1:0] miss_total,
  input logic [CNT_W-1:0] evict_total
);
  // High from the second edge after reset release, so $past sees reset values.
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  a_r3_single_outcome: assert property (@(posedge clk) disable iff (rst)
    !(out_hit && out_miss));

  a_r3_evict_needs_miss: assert property (@(posedge clk) disable iff (rst)
    out_evict |-> out_miss);

  a_r3_outcome_follows_req: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (out_hit || out_miss));

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst || !armed)
    (out_hit || out_miss) |-> $past(req_valid && req_ready));

  a_r7_hit_step: assert property (@(posedge clk) disable iff (rst || !armed)
    hit_total == $past(hit_total) + CNT_W'(out_hit));

  a_r7_miss_step: assert property (@(posedge clk) disable iff (rst || !armed)
    miss_total == $past(miss_total) + CNT_W'(out_miss));

  a_r7_evict_step: assert property (@(posedge clk) disable iff (rst || !armed)
    evict_total == $past(evict_total) + CNT_W'(out_evict));

  a_r7_evict_bounded: assert property (@(posedge clk) disable iff (rst)
    evict_total <= miss_total);
endmodule

bind lru_tag_cache lru_tag_cache_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_lru_tag_cache.sv
module tb_lru_tag_cache;
  localparam int CLK_PERIOD = 10;
  localparam int S = 4;
  localparam int E = 2;
  localparam int B = 4;
  localparam int NSETS = 1 << S;

  typedef struct {
    logic [2:0] flags;   // {evict, miss, hit}
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [63:0] req_addr = '0;
  logic        req_ready;
  logic        out_hit, out_miss, out_evict;
  logic [31:0] hit_total, miss_total, evict_total;

  int checks = 0;
  int fails  = 0;
  exp_t sb[$];

  // Bench reference: last-use timestamps, lowest free way first.
  logic        m_valid [NSETS][E];
  logic [63:0] m_tag   [NSETS][E];
  longint      m_stamp [NSETS][E];
  longint      m_now;
  int          m_hits, m_misses, m_evicts, m_reqs;

  lru_tag_cache #(.ADDR_W(64), .SET_BITS(S), .WAYS(E), .BLK_BITS(B), .CNT_W(32)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .out_hit(out_hit),
    .out_miss(out_miss), .out_evict(out_evict), .hit_total(hit_total),
    .miss_total(miss_total), .evict_total(evict_total)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < E; w++) begin
        m_valid[s][w] = 1'b0; m_tag[s][w] = '0; m_stamp[s][w] = 0;
      end
    m_now = 0; m_hits = 0; m_misses = 0; m_evicts = 0; m_reqs = 0;
  endtask

  task automatic model_access(input logic [63:0] a, output logic [2:0] f);
    int s, victim;
    logic [63:0] t;
    s = int'((a >> B) & 64'(NSETS - 1));
    t = a >> (B + S);
    m_now++; m_reqs++;
    f = 3'b000;
    for (int w = 0; w < E; w++)
      if (m_valid[s][w] && m_tag[s][w] == t) begin
        f = 3'b001; m_stamp[s][w] = m_now;
      end
    if (f == 3'b000) begin
      victim = -1;
      for (int w = 0; w < E; w++)
        if (!m_valid[s][w] && victim < 0) victim = w;
      if (victim < 0) begin
        victim = 0;
        for (int w = 1; w < E; w++)
          if (m_stamp[s][w] < m_stamp[s][victim]) victim = w;
        f = 3'b110;
      end else f = 3'b010;
      m_valid[s][victim] = 1'b1; m_tag[s][victim] = t; m_stamp[s][victim] = m_now;
    end
    if (f[0]) m_hits++;
    if (f[1]) m_misses++;
    if (f[2]) m_evicts++;
  endtask

  // Driver: one request, expected outcome pushed after the capturing edge.
  task automatic issue(input logic st, input logic [63:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = a;
    model_access(a, e.flags);
    e.tag = tag;
    @(posedge clk);
    #1;
    sb.push_back(e);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  // Monitor: compares the pulses seen after each accepted request.
  always @(negedge clk) begin
    if (!rst) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({out_evict, out_miss, out_hit} == e.flags, e.tag,
              longint'({out_evict, out_miss, out_hit}), longint'(e.flags));
      end else if (out_hit || out_miss || out_evict) begin
        check(1'b0, "R3 pulse without request",
              longint'({out_evict, out_miss, out_hit}), 0);
      end
    end
  end

  task automatic check_totals(input string tag);
    check(hit_total == 32'(m_hits), {tag, " hits"}, hit_total, m_hits);
    check(miss_total == 32'(m_misses), {tag, " misses"}, miss_total, m_misses);
    check(evict_total == 32'(m_evicts), {tag, " evictions"}, evict_total, m_evicts);
  endtask

  task automatic finish_report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_report();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, R9: ready
    check(hit_total == 0 && miss_total == 0 && evict_total == 0, "R1 totals after reset",
          hit_total + miss_total + evict_total, 0);
    check({out_hit, out_miss, out_evict} == 3'b000, "R1 pulses after reset",
          {out_hit, out_miss, out_evict}, 0);
    check(req_ready == 1'b1, "R9 ready", req_ready, 1);

    // R8: trace example, back to back (R9)
    issue(0, 64'h10,  "R8 L10");
    issue(0, 64'h20,  "R8 L20");
    issue(1, 64'h20,  "R8 S20");
    issue(0, 64'h22,  "R8 L22");
    issue(1, 64'h18,  "R8 S18");
    issue(0, 64'h110, "R8 L110");
    issue(0, 64'h210, "R8 L210");
    issue(0, 64'h12,  "R8 L12");
    issue(1, 64'h12,  "R8 S12");
    drain();
    check(hit_total == 4,   "R8 hits",      hit_total, 4);
    check(miss_total == 5,  "R8 misses",    miss_total, 5);
    check(evict_total == 2, "R8 evictions", evict_total, 2);

    // R1: reset invalidates lines
    do_reset();
    check(hit_total == 0 && miss_total == 0 && evict_total == 0, "R1 totals cleared",
          hit_total + miss_total + evict_total, 0);
    issue(0, 64'h10, "R1 miss after reset no evict");
    drain();

    // R2: offset ignored, set bits select the set
    issue(0, 64'h1000, "R2 first miss");
    issue(0, 64'h100F, "R2 same block other offset hits");
    issue(0, 64'h1010, "R2 next set misses");
    issue(0, 64'h2000, "R2 other tag same set fills free way");

    // R5 and R6 in set 3
    issue(0, 64'hA030, "R5 fill way0");
    issue(0, 64'hB030, "R5 fill way1 no evict");
    issue(0, 64'hA034, "R6 touch A");
    issue(0, 64'hC030, "R6 C evicts LRU B");
    issue(0, 64'hB030, "R6 B misses evicts A");
    issue(0, 64'hC03F, "R6 C still present");

    // R4: store miss allocates
    issue(1, 64'h7750, "R4 store miss");
    issue(0, 64'h7758, "R4 load after store hits");
    drain();
    check_totals("R4 totals");

    // R3: idle cycles change nothing
    repeat (4) @(negedge clk);
    check_totals("R3 idle totals");

    // R10: random stream against the reference replay
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      a = (64'($urandom_range(5)) << 8) | (64'($urandom_range(3)) << 4) | 64'($urandom_range(15));
      issue(1'($urandom_range(1)), a, "R10 random outcome");
    end
    drain();
    check_totals("R10 random totals");
    check(hit_total + miss_total == 32'(m_reqs), "R10 hits plus misses",
          hit_total + miss_total, m_reqs);
    check(evict_total <= miss_total, "R7 evictions bounded", evict_total, miss_total);

    finish_report();
  end
endmodule